// File: doc/BRIEF.md
# Eight-Pin Bidirectional Port Controller

This block drives eight general-purpose pads from a small register bus. Per pin it holds an output latch, a direction bit, an analog-select bit and, on the upper pins, a pull-up control. From these it produces an output enable, an output value and a pull-up request for each pad. It takes the pad level back in through a two-flop synchronizer. A single configuration bit turns every pull-up off at once, and it comes out of reset in the off state.

Software reads the data register to see what the pins are doing, not what it last wrote. A pin marked analog reads as zero on that path, but it can still drive as a digital output. The bus supports whole-register writes and single-mask set and clear operations. On the data register, set and clear start from the pin levels, not from the latch. Because of this, an input pin's latch bit gets overwritten with whatever level the pin currently shows.

Top module: `gpio_port8`

## Requirements
- R1: After reset the direction register is all ones, the output latch is zero, the analog-select register equals parameter ANA_RST (default 0xFF), the pull-up control register is zero, and no pad is driven (pad_oe = 0).
- R2: For each pin, pad_oe is 1 exactly when its direction bit (register address 1) is 0, and pad_out always shows the output latch.
- R3: A read of the data register (address 0) returns pad levels after the two-flop synchronizer, not the latch contents. A full write (op 1) to address 0 loads the latch.
- R4: On a data register read, every pin whose analog-select bit (address 2) is 1 returns 0.
- R5: The analog-select bits do not change pad_oe or pad_out.
- R6: A pin's pad_pu is 1 only when its pull-up control bit is 1, its direction bit is 1 (input), and the global disable is 0.
- R7: The global pull-up disable is bit 0 of address 4. It resets to 1, and while it is 1 every pad_pu is 0.
- R8: Pull-up control (address 3) exists only for pins 7 to 4. Bits 3 to 0 read as 0, and pad_pu[3:0] stays 0.
- R9: A set (op 2) or clear (op 3) on address 0 computes its result from the masked pin read value OR / AND-NOT the bus mask, and writes that result to the latch. This lets input pins overwrite their own latch bits.
- R10: Set and clear on addresses 1 to 4 modify the stored register value with the bus mask.
- R11: Addresses 5 to 7 read as 0, and writes to them change nothing.
- R12: Read data (op 0) appears on bus_rdata in the cycle after the request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access strobe, one cycle per operation |
| bus_op | input | 2 | 0 read, 1 write, 2 set bits, 3 clear bits |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data or bit mask |
| bus_rdata | output | 8 | Read data, registered |
| pad_in | input | 8 | Sampled pad levels |
| pad_oe | output | 8 | Pad output driver enable |
| pad_out | output | 8 | Pad output value |
| pad_pu | output | 8 | Pad weak pull-up enable |

## Verification
The hardest case to reach is a set or clear on the data register that rewrites the latch bits of input pins from their pad levels. To reach it, the bench models the pads: each pad follows the driver when enabled, otherwise an external source, otherwise its pull-up. It then makes the latch and the external levels disagree on the input pins before issuing the mask operation. It repeats the operation with an input pin marked analog, so the zero from the read path lands in the latch. Pull-up gating is reached by clearing the global disable and then moving pins between input and output.

// File: rtl/gpio_port8_pkg.sv
package gpio_port8_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLR   = 2'd3
  } bus_op_e;

  localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIR  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ANA  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PULL = 3'd3;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port8_pkg::*;
#(
  parameter int          W       = 8,
  parameter int          PU_LO   = 4,
  parameter logic [W-1:0] ANA_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  bus_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      pin_view,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      latch,
  output logic [W-1:0]      dir,
  output logic [W-1:0]      ana,
  output logic [W-1:0]      pull,
  output logic              goff
);
  localparam logic [W-1:0] PU_MASK = {W{1'b1}} << PU_LO;

  logic [W-1:0] latch_q, latch_d, dir_q, dir_d, ana_q, ana_d, pull_q, pull_d;
  logic [W-1:0] rdata_q, rdata_d, pin_rd;
  logic         goff_q, goff_d;
  logic         mod_hit, rd_hit;
  logic         latch_en, dir_en, ana_en, pull_en, cfg_en;

  function automatic logic [W-1:0] apply_op(input logic [W-1:0] cur,
                                             input bus_op_e o,
                                             input logic [W-1:0] m);
    case (o)
      OP_SET:  apply_op = cur | m;
      OP_CLR:  apply_op = cur & ~m;
      default: apply_op = m;
    endcase
  endfunction

  // next-state logic
  always_comb begin
    pin_rd   = pin_view & ~ana_q;
    mod_hit  = req && (op != OP_READ);
    rd_hit   = req && (op == OP_READ);
    latch_en = mod_hit && (addr == A_DATA);
    dir_en   = mod_hit && (addr == A_DIR);
    ana_en   = mod_hit && (addr == A_ANA);
    pull_en  = mod_hit && (addr == A_PULL);
    cfg_en   = mod_hit && (addr == A_CFG);

    latch_d = apply_op(pin_rd, op, wdata);
    dir_d   = apply_op(dir_q, op, wdata);
    ana_d   = apply_op(ana_q, op, wdata);
    pull_d  = apply_op(pull_q, op, wdata) & PU_MASK;
    goff_d  = apply_op({{(W-1){1'b0}}, goff_q}, op, wdata) [0];

    case (addr)
      A_DATA:  rdata_d = pin_rd;
      A_DIR:   rdata_d = dir_q;
      A_ANA:   rdata_d = ana_q;
      A_PULL:  rdata_d = pull_q;
      A_CFG:   rdata_d = {{(W-1){1'b0}}, goff_q};
      default: rdata_d = '0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '1;
      ana_q   <= ANA_RST;
      pull_q  <= '0;
      goff_q  <= 1'b1;
      rdata_q <= '0;
    end else begin
      if (latch_en) latch_q <= latch_d;
      if (dir_en)   dir_q   <= dir_d;
      if (ana_en)   ana_q   <= ana_d;
      if (pull_en)  pull_q  <= pull_d;
      if (cfg_en)   goff_q  <= goff_d;
      if (rd_hit)   rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
  assign latch = latch_q;
  assign dir   = dir_q;
  assign ana   = ana_q;
  assign pull  = pull_q;
  assign goff  = goff_q;

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && (op != OP_READ) && (addr == A_DATA)) |=> $stable(latch_q)); // R11
  AST_WRITE_LOADS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (op == OP_WRITE) && (addr == A_DATA)) |=> (latch_q == $past(wdata))); // R3
  AST_SET_FROM_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (op == OP_SET) && (addr == A_DATA))
      |=> (latch_q == ($past(pin_view & ~ana_q) | $past(wdata)))); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && (op == OP_READ)) |=> $stable(rdata_q)); // R12
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (op == OP_READ) && (addr > A_CFG)) |=> (rdata_q == '0)); // R11
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int W     = 8,
  parameter int PU_LO = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] latch,
  input  logic [W-1:0] pull,
  input  logic         goff,
  output logic [W-1:0] oe,
  output logic [W-1:0] out,
  output logic [W-1:0] pu
);
  localparam logic [W-1:0] PU_MASK = {W{1'b1}} << PU_LO;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      assign oe[i]  = ~dir[i];
      assign out[i] = latch[i];
      if (i >= PU_LO) begin : g_pu
        assign pu[i] = pull[i] & dir[i] & ~goff;
      end else begin : g_nopu
        assign pu[i] = 1'b0;
      end
    end
  endgenerate

  AST_PU_OFF_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (pu & oe) == '0); // R6
  AST_PU_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    goff |-> (pu == '0)); // R7
  AST_PU_LOW_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pu & ~PU_MASK) == '0); // R8
endmodule

// File: rtl/gpio_port8.sv
module gpio_port8
  import gpio_port8_pkg::*;
#(
  parameter int           W       = 8,
  parameter int           PU_LO   = 4,
  parameter int           SYNC_N  = 2,
  parameter logic [W-1:0] ANA_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic [1:0]        bus_op,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_pu
);
  logic [1:0]   rst_pipe;
  logic         rst_sn;
  logic [W-1:0] pin_view, latch, dir, ana, pull;
  logic         goff;
  bus_op_e      op_e;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];
  assign op_e   = bus_op_e'(bus_op);

  gpio_sync #(.W(W), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_sn), .d(pad_in), .q(pin_view)
  );

  gpio_regfile #(.W(W), .PU_LO(PU_LO), .ANA_RST(ANA_RST)) u_regs (
    .clk(clk), .rst_n(rst_sn), .req(bus_req), .op(op_e), .addr(bus_addr),
    .wdata(bus_wdata), .pin_view(pin_view), .rdata(bus_rdata),
    .latch(latch), .dir(dir), .ana(ana), .pull(pull), .goff(goff)
  );

  gpio_pad_ctrl #(.W(W), .PU_LO(PU_LO)) u_pads (
    .clk(clk), .rst_n(rst_sn), .dir(dir), .latch(latch), .pull(pull),
    .goff(goff), .oe(pad_oe), .out(pad_out), .pu(pad_pu)
  );

  AST_ANALOG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_req && (op_e == OP_READ) && (bus_addr == A_DATA))
      |=> ((bus_rdata & $past(ana)) == '0)); // R4
  AST_ANALOG_NO_DRIVE_EFFECT: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_req && (op_e != OP_READ) && (bus_addr == A_ANA))
      |=> ($stable(pad_oe) && $stable(pad_out))); // R5
endmodule

// File: tb/gpio_port8_bench.sv
module gpio_port8_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req;
  logic [1:0]   op;
  logic [2:0]   addr;
  logic [W-1:0] wdata;
  logic [W-1:0] rdata, oe, out, pu;
  logic [W-1:0] pad_in, ext_en, ext_val;
  logic         pend;
  logic         done;
  int           n_chk, n_fail;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #2 clk = ~clk;

  // pad model: driver, else external source, else pull-up, else low
  always_comb begin
    for (int i = 0; i < W; i++)
      pad_in[i] = oe[i] ? out[i] : (ext_en[i] ? ext_val[i] : pu[i]);
  end

  gpio_port8 u_gpio_port8 (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_op(op), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .pad_in(pad_in), .pad_oe(oe),
    .pad_out(out), .pad_pu(pu)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic [1:0] o, input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    req = 1'b1; op = o; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; op = 2'd0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [W-1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus(2'd0, a, '0);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(posedge clk) pend <= req && (op == 2'd0);
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R12 unexpected read result actual=%h expected=none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    done = 1'b0;
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; pend = 1'b0;
    rst_n = 1'b0; req = 1'b0; op = '0; addr = '0; wdata = '0;
    ext_en = 8'hFF; ext_val = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R1 pad_oe after reset", oe, 8'h00);
    check("R1 pad_out after reset", out, 8'h00);
    check("R7 pad_pu after reset", pu, 8'h00);
    rd(3'd1, 8'hFF, "R1 direction reset");
    rd(3'd2, 8'hFF, "R1 analog reset");
    rd(3'd3, 8'h00, "R1 pull-up reset");
    rd(3'd4, 8'h01, "R7 global disable reset");
    rd(3'd0, 8'h00, "R4 all-analog data read");

    bus(2'd1, 3'd2, 8'h00);
    settle();
    rd(3'd0, 8'hA5, "R3 pins read");
    bus(2'd1, 3'd0, 8'h3C);
    check("R2 pad_out is latch", out, 8'h3C);
    check("R2 inputs not driven", oe, 8'h00);
    settle();
    rd(3'd0, 8'hA5, "R3 read ignores latch");

    bus(2'd1, 3'd1, 8'h0F);
    check("R2 oe from direction", oe, 8'hF0);
    settle();
    rd(3'd0, 8'h35, "R3 mixed pins");

    bus(2'd1, 3'd2, 8'h30);
    settle();
    rd(3'd0, 8'h05, "R4 analog pins read zero");
    check("R5 analog keeps pad_out", out, 8'h3C);
    check("R5 analog keeps pad_oe", oe, 8'hF0);
    bus(2'd1, 3'd2, 8'h00);

    bus(2'd1, 3'd3, 8'hFF);
    rd(3'd3, 8'hF0, "R8 low pull-up bits absent");
    check("R7 global disable holds pulls off", pu, 8'h00);
    bus(2'd3, 3'd4, 8'h01);
    rd(3'd4, 8'h00, "R10 clear on config");
    check("R6 pull off on outputs", pu, 8'h00);
    bus(2'd1, 3'd1, 8'hFF);
    check("R6 pull on inputs", pu, 8'hF0);
    bus(2'd3, 3'd1, 8'h80);
    check("R6 pull follows direction", pu, 8'h70);
    rd(3'd1, 8'h7F, "R10 clear on direction");
    bus(2'd2, 3'd4, 8'h01);
    check("R7 global disable set", pu, 8'h00);

    ext_en = 8'h0F; ext_val = 8'h0A;
    bus(2'd1, 3'd1, 8'h0F);
    settle();
    bus(2'd2, 3'd0, 8'h01);
    check("R9 set from pins", out, 8'h3B);
    settle();
    bus(2'd3, 3'd0, 8'h20);
    check("R9 clear from pins", out, 8'h1A);
    bus(2'd1, 3'd2, 8'h08);
    settle();
    bus(2'd2, 3'd0, 8'h00);
    check("R9 analog zero enters latch", out, 8'h12);
    bus(2'd1, 3'd2, 8'h00);

    bus(2'd1, 3'd6, 8'hFF);
    rd(3'd6, 8'h00, "R11 unmapped read");
    rd(3'd5, 8'h00, "R11 unmapped read 5");
    rd(3'd1, 8'h0F, "R11 unmapped write no effect");
    check("R11 latch untouched", out, 8'h12);

    repeat (3) @(negedge clk);
    check("R12 read data held", rdata, 8'h0F);
    bus(2'd1, 3'd1, 8'hFF);
    check("R12 held across write", rdata, 8'h0F);

    settle();
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R12 missing read results actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule